// File: doc/BRIEF.md
# Root Port Error and PME Signaling Control

This block sits beside a root port and owns its 16-bit root control register. Three of its bits choose which error severities (correctable, non-fatal uncorrectable, fatal) may raise a system error. The fourth bit enables an interrupt for power-management event (PME) messages. Error events reach the block as one-cycle pulses on two 3-bit buses. One bus carries errors the port detected itself, the other carries error messages received from downstream devices. Bit k of either bus stands for the severity that control bit k enables.

The block turns qualifying error pulses into a one-cycle SERR pulse. The per-severity enables alone decide whether a pulse is produced. The legacy command-register SERR enable input has no influence on it. A received PME message sets a sticky status bit, which software clears by writing 1. While that status and the PME enable are both set, an interrupt request is held high. The request therefore also appears when the enable is turned on while a PME is already pending.

Top module: `rp_err_pme_ctl`

## Requirements
- R1: After reset, the control bits, `rd_data`, `serr`, `pme_status` and `pme_irq` are all 0.
- R2: `rd_data[15:4]` always reads 0, and write data in bits 15:4 is discarded.
- R3: A write with `wr_en` high loads `wr_data[3:0]` into the control bits at the clock edge, and `rd_data[3:0]` shows them from the next cycle.
- R4: Control bit 0 enables correctable errors, bit 1 non-fatal uncorrectable errors and bit 2 fatal errors. Those severities are carried on index 0, 1 and 2 of `loc_err` and `msg_err`. A pulse on either bus raises `serr` in the following cycle only when the enable for that index is 1.
- R5: `cmd_serr_en` neither suppresses nor forces `serr`.
- R6: `serr` is high for exactly one cycle per cycle of qualifying events. Several severities arriving in the same cycle give a single pulse.
- R7: A `pme_msg` pulse sets `pme_status` in the next cycle, whatever the value of control bit 3.
- R8: `pme_irq` is high exactly while `pme_status` and control bit 3 are both 1.
- R9: Writing control bit 3 from 0 to 1 while `pme_status` is 1 raises `pme_irq` in the next cycle.
- R10: A `pme_clr` pulse (software writing 1 to status) clears `pme_status`. If `pme_msg` arrives in the same cycle, the status stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low core reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 16 | Control register write data |
| rd_data | output | 16 | Control register read value |
| loc_err | input | 3 | Locally detected error pulses, index = severity |
| msg_err | input | 3 | Received error message pulses, index = severity |
| pme_msg | input | 1 | PME message received pulse |
| pme_clr | input | 1 | Software write-1-to-clear of PME status |
| cmd_serr_en | input | 1 | Legacy command-register SERR enable (no effect) |
| serr | output | 1 | One-cycle system error pulse |
| pme_irq | output | 1 | PME interrupt request |
| pme_status | output | 1 | Sticky PME status |

## Verification
The embedded assertions check four things on every cycle. The reserved read bits stay zero after writes. Every SERR pulse is preceded by an error pulse. A PME message always leaves the status set. A clear without a competing message empties it. A fifth assertion checks that a rising PME enable over pending status yields the interrupt. The assertions cannot show the mapping of each control bit to its severity, the indifference to the command-register enable, or the merging of simultaneous errors into one pulse. Only the bench's directed scenarios show these, by sweeping the enables against each error index and comparing SERR with expected values.

// File: rtl/rp_err_pme_ctl.sv
module rp_err_pme_ctl #(
  parameter int REG_W = 16,
  parameter int NCLS  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic [NCLS-1:0]  loc_err,
  input  logic [NCLS-1:0]  msg_err,
  input  logic             pme_msg,
  input  logic             pme_clr,
  input  logic             cmd_serr_en,
  output logic             serr,
  output logic             pme_irq,
  output logic             pme_status
);
  localparam int CTL_W   = NCLS + 1;
  localparam int PME_BIT = NCLS;

  logic [CTL_W-1:0] ctl_q;
  logic             hit;
  logic             unused_ok;

  assign unused_ok = cmd_serr_en ^ (|wr_data[REG_W-1:CTL_W]);
  assign hit       = |((loc_err | msg_err) & ctl_q[NCLS-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q      <= '0;
      serr       <= 1'b0;
      pme_status <= 1'b0;
    end else begin
      if (wr_en) ctl_q <= wr_data[CTL_W-1:0];
      serr <= hit;
      if (pme_msg)      pme_status <= 1'b1;
      else if (pme_clr) pme_status <= 1'b0;
    end
  end

  assign pme_irq = pme_status & ctl_q[PME_BIT];
  assign rd_data = {{(REG_W-CTL_W){1'b0}}, ctl_q};

  a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[REG_W-1:CTL_W] == '0);
  a_r4_serr_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    serr |-> $past(|(loc_err | msg_err)));
  a_r7_pme_sets: assert property (@(posedge clk) disable iff (!rst_n)
    pme_msg |=> pme_status);
  a_r9_enable_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[PME_BIT] && !rd_data[PME_BIT] && pme_status && !pme_clr) |=> pme_irq);
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (pme_clr && !pme_msg) |=> !pme_status);
endmodule

// File: tb/tb_rp_err_pme_ctl.sv
module tb_rp_err_pme_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [2:0]  loc_err = '0;
  logic [2:0]  msg_err = '0;
  logic        pme_msg = 1'b0;
  logic        pme_clr = 1'b0;
  logic        cmd_serr_en = 1'b0;
  logic        serr, pme_irq, pme_status;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  rp_err_pme_ctl dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
    wr_en = 0; loc_err = 0; msg_err = 0; pme_msg = 0; pme_clr = 0;
  endtask

  task automatic wr(input logic [15:0] d);
    wr_en = 1; wr_data = d; step();
  endtask

  task automatic t_reset;
    chk(rd_data == 0, "R1", rd_data, 0);
    chk(serr == 0, "R1", serr, 0);
    chk(pme_status == 0 && pme_irq == 0, "R1", {pme_status, pme_irq}, 0);
  endtask

  task automatic t_reg;
    wr(16'hFFFF);
    chk(rd_data == 16'h000F, "R2", rd_data, 16'h000F);
    wr(16'hA5A5);
    chk(rd_data == 16'h0005, "R3", rd_data, 16'h0005);
    wr(16'h0000);
    chk(rd_data == 16'h0000, "R3", rd_data, 0);
  endtask

  task automatic t_class;
    for (int k = 0; k < 3; k++) begin
      wr(16'(1 << k));
      for (int j = 0; j < 3; j++) begin
        loc_err = 3'(1 << j); step();
        chk(serr == (j == k), "R4 local", serr, int'(j == k));
        msg_err = 3'(1 << j); step();
        chk(serr == (j == k), "R4 message", serr, int'(j == k));
      end
    end
  endtask

  task automatic t_cmd;
    wr(16'h0000); cmd_serr_en = 1;
    loc_err = 3'b111; step();
    chk(serr == 0, "R5 no force", serr, 0);
    wr(16'h0004); cmd_serr_en = 0;
    msg_err = 3'b100; step();
    chk(serr == 1, "R5 no suppress", serr, 1);
  endtask

  task automatic t_multi;
    wr(16'h0007);
    loc_err = 3'b111; msg_err = 3'b011; step();
    chk(serr == 1, "R6 one pulse", serr, 1);
    step();
    chk(serr == 0, "R6 pulse ends", serr, 0);
  endtask

  task automatic t_pme;
    wr(16'h0000);
    pme_msg = 1; step();
    chk(pme_status == 1, "R7", pme_status, 1);
    chk(pme_irq == 0, "R8 disabled", pme_irq, 0);
    wr(16'h0008);
    chk(pme_irq == 1, "R9", pme_irq, 1);
    pme_clr = 1; step();
    chk(pme_status == 0 && pme_irq == 0, "R10 clear", {pme_status, pme_irq}, 0);
    pme_msg = 1; step();
    chk(pme_irq == 1, "R8 enabled", pme_irq, 1);
    pme_msg = 1; pme_clr = 1; step();
    chk(pme_status == 1, "R10 collision", pme_status, 1);
    wr(16'h0000);
    chk(pme_irq == 0 && pme_status == 1, "R8 enable off", {pme_status, pme_irq}, 2'b10);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1; step();
        t_reset();
        t_reg();
        t_class();
        t_cmd();
        t_multi();
        t_pme();
      end
      begin
        repeat (5000) @(negedge clk);
        chk(0, "watchdog", 0, 1);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule